// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the write-side front end of an eight-input programmable interrupt controller. Software reaches it through a byte-wide write interface with a command port and a data port. A command byte with bit 4 set starts an initialization. The following data bytes then fill the vector base, cascade and mode registers in turn. Flags in the first byte decide which of these steps are skipped. Once the sequence is done, the block is READY. Command bytes then act as end-of-interrupt or mode commands, and data bytes load the interrupt mask.

The block also holds the in-service register that the priority logic elsewhere sets. It clears entries in that register on a specific or a non-specific end-of-interrupt. Any illegal write raises a one-cycle error pulse and changes nothing. The sequencer has five states: IDLE (0), WAIT_VEC (1), WAIT_CAS (2), WAIT_MODE (3) and READY (4). The transitions are:
- IDLE→WAIT_VEC, and any state→WAIT_VEC, on an initialization command.
- WAIT_VEC→WAIT_CAS, WAIT_VEC→WAIT_MODE and WAIT_VEC→READY on a data write, chosen by the first-byte flags.
- WAIT_CAS→WAIT_MODE and WAIT_CAS→READY on a data write.
- WAIT_MODE→READY on a data write.

Top module: `irq_cmd_seq`

## Requirements
- R1: Synchronous active-high reset sets the state to IDLE (encoding 0) and clears the mask, in-service, init, vector, cascade, mode, op2 and op3 registers and the error output.
- R2: A legal command-port write with bit 4 = 1 is accepted in every state. It stores the byte in the init register and moves to WAIT_VEC (1) without error.
- R3: In WAIT_VEC, a data write stores the vector register. The next state is WAIT_CAS (2) if init bit 1 = 0. Otherwise it is WAIT_MODE (3) if init bit 0 = 1. Otherwise it is READY (4).
- R4: In WAIT_CAS, a data write stores the cascade register. The next state is WAIT_MODE if init bit 0 = 1, else READY.
- R5: In WAIT_MODE, a data write stores the mode register and moves to READY.
- R6: A data write in IDLE or READY loads the 8-bit mask register.
- R7: In READY, a command byte with bits 4:3 = 00, bit 7 = 0, bit 6 = 1 and bit 5 = 1 clears the in-service bit indexed by bits 2:0. The byte is stored in the op2 register.
- R8: In READY, a command byte with bits 4:3 = 00, bit 7 = 0, bit 6 = 0 and bit 5 = 1 clears only the lowest-numbered set in-service bit, or nothing if none is set. The byte is stored in op2.
- R9: The error output is high in the cycle after an illegal command write and low otherwise, and the write changes no state. Illegal command writes are:
  - a non-init command in IDLE, WAIT_VEC, WAIT_CAS or WAIT_MODE;
  - in READY, a bits 4:3 = 00 byte with bit 5 = 0 or bit 7 = 1.
- R10: In READY, a command byte with bits 4:3 = 01 is stored in the op3 register without error.
- R11: A write whose size code is not 1 (one byte) raises the error output and is ignored on either port.
- R12: Each bit set on the test input sets the matching in-service bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = command port, 1 = data port |
| wr_len | input | 2 | Access size code, 1 = one byte |
| wr_data | input | 8 | Write byte |
| tst_isr_set | input | 8 | Test-only in-service set bits |
| seq_state | output | 3 | Sequencer state encoding |
| err | output | 1 | Illegal-write pulse |
| mask_q | output | 8 | Interrupt mask |
| isr_q | output | 8 | In-service register |
| init_q | output | 8 | Stored first initialization byte |
| vec_q | output | 8 | Stored vector base byte |
| cas_q | output | 8 | Stored cascade byte |
| mode_q | output | 8 | Stored mode byte |
| op2_q | output | 8 | Last valid end-of-interrupt command |
| op3_q | output | 8 | Last mode-command byte |

## Verification
The bench runs all four combinations of the two first-byte skip flags. A design that decoded the flags the wrong way round, or with the wrong priority, would end in the wrong state after the vector byte.

The non-specific end-of-interrupt is repeated on a register with several bits set until the register is empty, and then once more. A design that scanned from the top bit, or that cleared several bits at once, would leave the wrong pattern.

Rejected end-of-interrupt codes, command writes in the middle of an initialization, and wrong access sizes each check that the error pulse appears and that the mask, op2 and state stay put. An initialization command issued from READY must restart the sequence.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int DATA_W  = 8;
    localparam int LVL_W   = $clog2(DATA_W);
    localparam int LEN_W   = 2;
    localparam logic [LEN_W-1:0] LEN_BYTE = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_VEC  = 3'd1,
        ST_WAIT_CAS  = 3'd2,
        ST_WAIT_MODE = 3'd3,
        ST_READY     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic             is_init;
        logic             is_op2;
        logic             is_op3;
        logic             op2_ok;
        logic             op2_spec;
        logic [LVL_W-1:0] level;
    } cmd_dec_t;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_seq_pkg::*;
(
    input  logic [DATA_W-1:0] byte_i,
    output cmd_dec_t          dec_o
);
    always_comb begin
        dec_o.is_init  = byte_i[4];
        dec_o.is_op2   = (byte_i[4:3] == 2'b00);
        dec_o.is_op3   = (byte_i[4:3] == 2'b01);
        dec_o.op2_ok   = (byte_i[4:3] == 2'b00) && byte_i[5] && !byte_i[7];
        dec_o.op2_spec = byte_i[6];
        dec_o.level    = byte_i[LVL_W-1:0];
    end
endmodule

// File: rtl/irq_isr_unit.sv
module irq_isr_unit
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_spec,
    input  logic              clr_low,
    input  logic [LVL_W-1:0]  level,
    input  logic [DATA_W-1:0] set_bits,
    output logic [DATA_W-1:0] isr_q
);
    logic [DATA_W-1:0] low_bit;
    logic [DATA_W-1:0] clr_vec;

    // isolate the lowest set bit
    assign low_bit = isr_q & (~isr_q + 1'b1);

    always_comb begin
        clr_vec = '0;
        if (clr_spec)
            clr_vec[level] = 1'b1;
        else if (clr_low)
            clr_vec = low_bit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            isr_q <= '0;
        else
            isr_q <= (isr_q & ~clr_vec) | set_bits;
    end

    // R8: at most one in-service bit drops per cycle
    p_one_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $countones($past(isr_q) & ~isr_q) <= 1);

    // R7: a specific clear removes the addressed bit
    p_spec_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_spec && set_bits == '0) |=> !isr_q[$past(level)]);

    // R12: test set bits appear next cycle
    p_test_set_r12: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(set_bits) & ~isr_q) == '0));
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] tst_isr_set,
    output logic [2:0]        seq_state,
    output logic              err,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] isr_q,
    output logic [DATA_W-1:0] init_q,
    output logic [DATA_W-1:0] vec_q,
    output logic [DATA_W-1:0] cas_q,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] op2_q,
    output logic [DATA_W-1:0] op3_q
);
    seq_state_e state_q, state_n;
    cmd_dec_t   dec;
    logic acc, bad_len, cmd_wr, dat_wr;
    logic ld_init, ld_vec, ld_cas, ld_mode, ld_mask, ld_op2, ld_op3;
    logic eoi_spec, eoi_low, err_n, err_q;

    irq_cmd_decode u_dec (.byte_i(wr_data), .dec_o(dec));

    irq_isr_unit u_isr (
        .clk(clk), .rst(rst),
        .clr_spec(eoi_spec), .clr_low(eoi_low),
        .level(dec.level), .set_bits(tst_isr_set),
        .isr_q(isr_q)
    );

    assign acc     = wr_en && (wr_len == LEN_BYTE);
    assign bad_len = wr_en && (wr_len != LEN_BYTE);
    assign cmd_wr  = acc && !wr_sel;
    assign dat_wr  = acc && wr_sel;

    always_comb begin
        state_n  = state_q;
        err_n    = bad_len;
        ld_init  = 1'b0; ld_vec = 1'b0; ld_cas = 1'b0; ld_mode = 1'b0;
        ld_mask  = 1'b0; ld_op2 = 1'b0; ld_op3 = 1'b0;
        eoi_spec = 1'b0; eoi_low = 1'b0;
        if (cmd_wr && dec.is_init) begin
            ld_init = 1'b1;
            state_n = ST_WAIT_VEC;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_wr) err_n = 1'b1;
                    else if (dat_wr) ld_mask = 1'b1;
                end
                ST_WAIT_VEC: begin
                    if (cmd_wr) err_n = 1'b1;
                    else if (dat_wr) begin
                        ld_vec = 1'b1;
                        if (!init_q[1])     state_n = ST_WAIT_CAS;
                        else if (init_q[0]) state_n = ST_WAIT_MODE;
                        else                state_n = ST_READY;
                    end
                end
                ST_WAIT_CAS: begin
                    if (cmd_wr) err_n = 1'b1;
                    else if (dat_wr) begin
                        ld_cas  = 1'b1;
                        state_n = init_q[0] ? ST_WAIT_MODE : ST_READY;
                    end
                end
                ST_WAIT_MODE: begin
                    if (cmd_wr) err_n = 1'b1;
                    else if (dat_wr) begin
                        ld_mode = 1'b1;
                        state_n = ST_READY;
                    end
                end
                ST_READY: begin
                    if (cmd_wr) begin
                        if (dec.op2_ok) begin
                            ld_op2   = 1'b1;
                            eoi_spec = dec.op2_spec;
                            eoi_low  = !dec.op2_spec;
                        end else if (dec.is_op3) begin
                            ld_op3 = 1'b1;
                        end else begin
                            err_n = 1'b1;
                        end
                    end else if (dat_wr) begin
                        ld_mask = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 1'b0;
            mask_q <= '0; init_q <= '0; vec_q <= '0; cas_q <= '0;
            mode_q <= '0; op2_q  <= '0; op3_q <= '0;
        end else begin
            err_q <= err_n;
            if (ld_mask) mask_q <= wr_data;
            if (ld_init) init_q <= wr_data;
            if (ld_vec)  vec_q  <= wr_data;
            if (ld_cas)  cas_q  <= wr_data;
            if (ld_mode) mode_q <= wr_data;
            if (ld_op2)  op2_q  <= wr_data;
            if (ld_op3)  op3_q  <= wr_data;
        end
    end

    assign seq_state = state_q;
    assign err       = err_q;

    // R11: wrong size flags an error and leaves state and mask alone
    p_bad_len_r11: assert property (@(posedge clk) disable iff (rst)
        (!rst && bad_len) |=> (err && state_q == $past(state_q) && mask_q == $past(mask_q)));

    // R2: an init command always goes to WAIT_VEC without error
    p_init_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst && cmd_wr && wr_data[4]) |=> (state_q == ST_WAIT_VEC && !err));

    // R6: mask moves only on a data write
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!rst && !(wr_en && wr_sel)) |=> $stable(mask_q));

    // R9: an error cycle follows a write that changed no state
    p_err_nochange_r9: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en) |=> (!err || (state_q == $past(state_q) && $stable(op2_q))));
endmodule

// File: tb/irq_cmd_seq_bench.sv
module irq_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0] wr_len = 2'd1;
    logic [7:0] wr_data = '0, tst_isr_set = '0;
    logic [2:0] seq_state;
    logic       err;
    logic [7:0] mask_q, isr_q, init_q, vec_q, cas_q, mode_q, op2_q, op3_q;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cmd_seq u_irq_cmd_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_len(wr_len),
        .wr_data(wr_data), .tst_isr_set(tst_isr_set), .seq_state(seq_state),
        .err(err), .mask_q(mask_q), .isr_q(isr_q), .init_q(init_q),
        .vec_q(vec_q), .cas_q(cas_q), .mode_q(mode_q), .op2_q(op2_q), .op3_q(op3_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [1:0] len, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_len = len; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_isr(input logic [7:0] v);
        @(negedge clk);
        tst_isr_set = v;
        @(posedge clk);
        @(negedge clk);
        tst_isr_set = '0;
    endtask

    task automatic t_reset;
        chk("R1 state", seq_state, 0); chk("R1 mask", mask_q, 0);
        chk("R1 isr", isr_q, 0);       chk("R1 err", err, 0);
        chk("R1 init", init_q, 0);     chk("R1 op2", op2_q, 0);
    endtask

    task automatic t_idle;
        wr(1, 1, 8'hA5); chk("R6 mask idle", mask_q, 8'hA5); chk("R6 err", err, 0);
        wr(0, 1, 8'h20); chk("R9 cmd idle err", err, 1); chk("R9 idle state", seq_state, 0);
    endtask

    task automatic t_full_init;
        wr(0, 1, 8'h11); chk("R2 state", seq_state, 1); chk("R2 init", init_q, 8'h11);
        chk("R2 err", err, 0);
        wr(1, 1, 8'h20); chk("R3 vec", vec_q, 8'h20); chk("R3 to cas", seq_state, 2);
        wr(0, 1, 8'h20); chk("R9 cmd mid init", err, 1); chk("R9 state held", seq_state, 2);
        wr(1, 1, 8'h04); chk("R4 cas", cas_q, 8'h04); chk("R4 to mode", seq_state, 3);
        wr(1, 1, 8'h01); chk("R5 mode", mode_q, 8'h01); chk("R5 ready", seq_state, 4);
        chk("R5 mask kept", mask_q, 8'hA5);
        wr(1, 1, 8'h3C); chk("R6 mask ready", mask_q, 8'h3C);
    endtask

    task automatic t_skip_variants;
        wr(0, 1, 8'h12); wr(1, 1, 8'h08); chk("R3 single no4 ready", seq_state, 4);
        wr(0, 1, 8'h13); wr(1, 1, 8'h09); chk("R3 single need4", seq_state, 3);
        wr(1, 1, 8'h02); chk("R5 ready", seq_state, 4);
        wr(0, 1, 8'h10); wr(1, 1, 8'h0A); chk("R3 cascade", seq_state, 2);
        wr(1, 1, 8'h0B); chk("R4 no4 ready", seq_state, 4); chk("R4 cas", cas_q, 8'h0B);
    endtask

    task automatic t_eoi;
        set_isr(8'h96); chk("R12 isr set", isr_q, 8'h96);
        wr(0, 1, 8'h64); chk("R7 spec clear", isr_q, 8'h86); chk("R7 op2", op2_q, 8'h64);
        wr(0, 1, 8'h20); chk("R8 lowest", isr_q, 8'h84); chk("R8 op2", op2_q, 8'h20);
        wr(0, 1, 8'h20); chk("R8 lowest2", isr_q, 8'h80);
        wr(0, 1, 8'h20); chk("R8 lowest3", isr_q, 8'h00);
        wr(0, 1, 8'h20); chk("R8 empty", isr_q, 8'h00); chk("R8 empty err", err, 0);
    endtask

    task automatic t_bad_op2;
        set_isr(8'h01);
        wr(0, 1, 8'hA0); chk("R9 R=1 err", err, 1); chk("R9 isr kept", isr_q, 8'h01);
        chk("R9 op2 kept", op2_q, 8'h20); chk("R9 state", seq_state, 4);
        wr(0, 1, 8'h40); chk("R9 eoi0 err", err, 1); chk("R9 isr kept2", isr_q, 8'h01);
        @(negedge clk); chk("R9 pulse ends", err, 0);
    endtask

    task automatic t_op3;
        wr(0, 1, 8'h0B); chk("R10 op3", op3_q, 8'h0B); chk("R10 err", err, 0);
        chk("R10 isr kept", isr_q, 8'h01);
    endtask

    task automatic t_len;
        wr(1, 2, 8'hFF); chk("R11 data err", err, 1); chk("R11 mask kept", mask_q, 8'h3C);
        wr(0, 0, 8'h11); chk("R11 cmd err", err, 1); chk("R11 state kept", seq_state, 4);
        chk("R11 init kept", init_q, 8'h10);
    endtask

    task automatic t_restart;
        wr(0, 1, 8'h13); chk("R2 restart", seq_state, 1); chk("R2 init", init_q, 8'h13);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_idle();
        t_full_init();
        t_skip_variants();
        t_eoi();
        t_bad_op2();
        t_op3();
        t_len();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule